// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Repeater

This block joins two segments, A and B, of one open-drain signal line, such as the clock or the data line of an I2C bus. Each side gives the block a sampled line level and takes from it a pull request that, when high, turns the pad into an open-drain driver that pulls that segment low. When the pull request is low the pad is a high-impedance input and an external resistor holds the segment high. When an outside device pulls either segment low, the block pulls the other segment low. There is no direction pin: the side that goes low first decides the direction.

When the outside device lets go, the block stops driving the far segment. That segment then rises slowly through its pull-up, and for a while it still reads low. A hold-off timer started by the falling pull request blocks the reverse path during that window, so the slow rise cannot echo back and latch the bus low. The window length is the parameter `HOLD_CYCLES`. It must stay well below one bit period at 400 kbit/s, which is 250 cycles at 100 MHz. Both line levels pass through multi-stage synchronizers before use. A global enable forces both pull requests off and clears the timers. Two instances, one per line, make a full two-wire repeater.

Top module: `od_line_repeater`

## Requirements
- R1: After reset, and whenever both segments read high with no hold-off running, both pull outputs (`a_pull_o`, `b_pull_o`) are 0.
- R2: With `en`=1, B's pull idle, B reading high and no lockout from side A, a low level on `a_lvl_i` first seen at a rising edge sets `b_pull_o` to 1 after the third rising edge. The sequence is two synchronizer stages, then one output register. `a_pull_o` stays 0 while B is low only because of this drive.
- R3: The mirror of R2 holds: a low on `b_lvl_i` drives `a_pull_o` to 1 three edges later, and `b_pull_o` stays 0.
- R4: While `b_pull_o` is 1, `a_lvl_i` returning high clears `b_pull_o` after the third rising edge. The mirror holds for side B.
- R5: Once a side's pull output falls, that side's low level cannot raise the opposite pull output for `HOLD_CYCLES` cycles. If that side is then held low from outside, the opposite pull output rises exactly `HOLD_CYCLES`+1 rising edges after the pull output fell.
- R6: `en`=0 at a rising edge forces both pull outputs to 0 after that edge, and they stay 0 while `en` stays 0. The hold-off timers are cleared.
- R7: A side that already reads low while not being driven by the block is never newly driven. So if both segments go low from outside together, neither pull output is set.
- R8: From the state in R7, releasing one side while the other stays held low drives the released side low three edges later. Releasing the second side then frees both segments.
- R9: `a_pull_o` and `b_pull_o` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling and timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Global enable; 0 disables both drivers |
| a_lvl_i | input | 1 | Level read on segment A (asynchronous) |
| b_lvl_i | input | 1 | Level read on segment B (asynchronous) |
| a_pull_o | output | 1 | 1 = pull segment A low, 0 = release A |
| b_pull_o | output | 1 | 1 = pull segment B low, 0 = release B |

## Verification
The hardest case to reach from the ports is the exact end of the hold-off window. A slow-rising segment normally comes back high long before the window closes, so the window's edge never shows. The bench releases side A and, in the same cycle, holds side B low from outside. B then keeps reading low after its pull request falls, and the bench checks that A's pull output stays 0 at edge `HOLD_CYCLES` and rises at the following edge. A bus model in the bench delays each segment's rise after the block releases it, which exercises the echo path during the normal copy-and-release cases.

// File: rtl/odr_pkg.sv
package odr_pkg;
   localparam int unsigned SIDES = 2;

   typedef enum logic {
      SIDE_A = 1'b0,
      SIDE_B = 1'b1
   } side_e;

   // index of the segment across the repeater from side i
   function automatic int unsigned far_side(input int unsigned i);
      return (SIDES - 1) - i;
   endfunction
endpackage

// File: rtl/odr_sync.sv
module odr_sync #(
   parameter int STAGES    = 2,
   parameter bit IDLE_LVL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= {STAGES{IDLE_LVL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/odr_drive.sv
module odr_drive (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic far_lvl_i,
   input  logic far_lock_i,
   input  logic near_lvl_i,
   output logic pull_o
);
   logic pull_q;
   logic want;

   // copy a low from the far side unless the far side is in lockout;
   // never start driving a near side that is already low on its own
   assign want = en_i & ~far_lvl_i & ~far_lock_i & (near_lvl_i | pull_q);

   always_ff @(posedge clk) begin
      if (!rst_n) pull_q <= 1'b0;
      else        pull_q <= want;
   end

   assign pull_o = pull_q;
endmodule

// File: rtl/odr_holdoff.sv
module odr_holdoff #(
   parameter int HOLD_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic pull_i,
   output logic lock_o
);
   generate
      if (HOLD_CYCLES == 0) begin : g_bare
         logic unused_bare;
         assign unused_bare = ^{clk, rst_n, en_i};
         assign lock_o      = pull_i;
      end else begin : g_timed
         localparam int CW = $clog2(HOLD_CYCLES + 1);
         localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYCLES);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n)              cnt_q <= '0;
            else if (!en_i)          cnt_q <= '0;
            else if (pull_i)         cnt_q <= RELOAD;
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         end

         assign lock_o = pull_i | (cnt_q != '0);
      end
   endgenerate
endmodule

// File: rtl/od_line_repeater.sv
module od_line_repeater #(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic a_lvl_i,
   input  logic b_lvl_i,
   output logic a_pull_o,
   output logic b_pull_o
);
   import odr_pkg::*;

   logic [SIDES-1:0] raw;
   logic [SIDES-1:0] lvl;
   logic [SIDES-1:0] pull;
   logic [SIDES-1:0] lock;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (HOLD_CYCLES < 0) begin : g_bad_hold
         $error("HOLD_CYCLES must not be negative");
      end
   endgenerate

   assign raw[SIDE_A] = a_lvl_i;
   assign raw[SIDE_B] = b_lvl_i;

   generate
      for (genvar i = 0; i < SIDES; i++) begin : g_side
         localparam int J = far_side(i);

         odr_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (raw[i]),
            .q_o   (lvl[i])
         );

         odr_drive u_drive (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (en),
            .far_lvl_i  (lvl[J]),
            .far_lock_i (lock[J]),
            .near_lvl_i (lvl[i]),
            .pull_o     (pull[i])
         );

         odr_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (en),
            .pull_i (pull[i]),
            .lock_o (lock[i])
         );
      end
   endgenerate

   assign a_pull_o = pull[SIDE_A];
   assign b_pull_o = pull[SIDE_B];
endmodule

// File: rtl/odr_checker.sv
module odr_checker #(
   parameter int HOLD_CYCLES = 16
) (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic a_s,
   input logic b_s,
   input logic a_pull,
   input logic b_pull
);
   localparam int CW = (HOLD_CYCLES < 1) ? 1 : $clog2(HOLD_CYCLES + 1);

   logic          a_prev, b_prev;
   logic [CW-1:0] win_a, win_b;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_prev <= 1'b0;
         b_prev <= 1'b0;
         win_a  <= '0;
         win_b  <= '0;
      end else begin
         a_prev <= a_pull;
         b_prev <= b_pull;
         if (!en || HOLD_CYCLES == 0)    win_a <= '0;
         else if (a_prev && !a_pull)     win_a <= CW'(HOLD_CYCLES);
         else if (win_a != '0)           win_a <= win_a - 1'b1;
         if (!en || HOLD_CYCLES == 0)    win_b <= '0;
         else if (b_prev && !b_pull)     win_b <= CW'(HOLD_CYCLES);
         else if (win_b != '0)           win_b <= win_b - 1'b1;
      end
   end

   // R9
   no_dual_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_pull && b_pull));
   // R6
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!a_pull && !b_pull));
   // R2
   b_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(b_pull) |-> $past(!a_s));
   // R3
   a_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(a_pull) |-> $past(!b_s));
   // R4
   b_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_s && b_pull) |=> !b_pull);
   // R4
   a_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_s && a_pull) |=> !a_pull);
   // R7
   both_low_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_s && !b_s && !a_pull && !b_pull) |=> (!a_pull && !b_pull));
   // R5
   b_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_b != '0) |-> !a_pull);
   // R5
   a_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_a != '0) |-> !b_pull);
endmodule

bind od_line_repeater odr_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .en     (en),
   .a_s    (lvl[0]),
   .b_s    (lvl[1]),
   .a_pull (a_pull_o),
   .b_pull (b_pull_o)
);

// File: tb/od_line_repeater_tb.sv
module od_line_repeater_tb;
   localparam int HOLD = 16;
   localparam int RISE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b1;
   logic a_ext = 1'b0, b_ext = 1'b0;
   int   a_rise = 0, b_rise = 0;
   logic a_lvl, b_lvl, a_pull_o, b_pull_o;
   int   checks = 0, fails = 0, overlap = 0;

   typedef struct {
      logic  ea;
      logic  eb;
      bit    ma;
      bit    mb;
      string tag;
   } exp_t;
   exp_t sb_q[$];

   always #5 clk = ~clk;

   od_line_repeater #(.SYNC_STAGES(2), .HOLD_CYCLES(HOLD)) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en),
      .a_lvl_i(a_lvl), .b_lvl_i(b_lvl),
      .a_pull_o(a_pull_o), .b_pull_o(b_pull_o)
   );

   // bus model: a segment released by the repeater rises slowly
   assign a_lvl = !(a_ext || a_pull_o || a_rise != 0);
   assign b_lvl = !(b_ext || b_pull_o || b_rise != 0);
   always @(negedge clk) begin
      if (a_pull_o) a_rise <= RISE; else if (a_rise != 0) a_rise <= a_rise - 1;
      if (b_pull_o) b_rise <= RISE; else if (b_rise != 0) b_rise <= b_rise - 1;
      if (rst_n && a_pull_o && b_pull_o) overlap <= overlap + 1;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
      #2;
   endtask

   task automatic expect_pulls(input logic ea, input logic eb,
                               input bit ma, input bit mb, input string tag);
      exp_t it;
      it.ea = ea; it.eb = eb; it.ma = ma; it.mb = mb; it.tag = tag;
      sb_q.push_back(it);
      wait (sb_q.size() == 0);
   endtask

   // monitor: pops expected items and compares against the outputs
   initial begin
      exp_t it;
      forever begin
         wait (sb_q.size() != 0);
         it = sb_q[0];
         if (it.ma) begin
            checks++;
            if (a_pull_o !== it.ea) begin
               fails++;
               $display("FAIL %s a_pull_o=%0b expected %0b", it.tag, a_pull_o, it.ea);
            end
         end
         if (it.mb) begin
            checks++;
            if (b_pull_o !== it.eb) begin
               fails++;
               $display("FAIL %s b_pull_o=%0b expected %0b", it.tag, b_pull_o, it.eb);
            end
         end
         void'(sb_q.pop_front());
      end
   end

   task automatic run_all();
      tick(4);
      rst_n = 1'b1;
      tick(5);
      expect_pulls(0, 0, 1, 1, "R1 idle after reset");

      // copy A low to B
      a_ext = 1'b1;
      tick(2);  expect_pulls(0, 0, 1, 1, "R2 before third edge");
      tick(1);  expect_pulls(0, 1, 1, 1, "R2 B driven after third edge");
      tick(10); expect_pulls(0, 1, 1, 1, "R2 no echo to A");

      // release A, B rises slowly, no echo
      a_ext = 1'b0;
      tick(2);  expect_pulls(0, 1, 1, 1, "R4 still driven before third edge");
      tick(1);  expect_pulls(0, 0, 1, 1, "R4 B released");
      for (int k = 0; k < 25; k++) begin
         tick(1); expect_pulls(0, 0, 1, 1, "R5 no echo during slow rise");
      end
      tick(10); expect_pulls(0, 0, 1, 1, "R1 idle after release");

      // mirror: B low copied to A
      b_ext = 1'b1;
      tick(3);  expect_pulls(1, 0, 1, 1, "R3 A driven from B");
      b_ext = 1'b0;
      tick(3);  expect_pulls(0, 0, 1, 1, "R4 A released");
      tick(30);

      // exact hold-off window: B held low outside as A lets go
      a_ext = 1'b1;
      tick(5);  expect_pulls(0, 1, 1, 1, "R2 B driven");
      a_ext = 1'b0; b_ext = 1'b1;
      tick(HOLD + 3); expect_pulls(0, 0, 1, 1, "R5 A blocked at last lockout edge");
      tick(1);  expect_pulls(1, 0, 1, 1, "R5 A driven after lockout");
      b_ext = 1'b0;
      tick(30); expect_pulls(0, 0, 1, 1, "R5 idle after window test");

      // both low together
      a_ext = 1'b1; b_ext = 1'b1;
      tick(5);  expect_pulls(0, 0, 1, 1, "R7 simultaneous low no drive");
      tick(20); expect_pulls(0, 0, 1, 1, "R7 stays undriven");
      a_ext = 1'b0;
      tick(3);  expect_pulls(1, 0, 1, 1, "R8 released A driven by held B");
      b_ext = 1'b0;
      tick(3);  expect_pulls(0, 0, 1, 1, "R8 all free after B release");
      tick(30);

      // enable off
      en = 1'b0; a_ext = 1'b1;
      tick(10); expect_pulls(0, 0, 1, 1, "R6 disabled no copy");
      a_ext = 1'b0;
      tick(10);
      en = 1'b1;
      a_ext = 1'b1;
      tick(5);  expect_pulls(0, 1, 1, 1, "R2 driven before disable");
      en = 1'b0;
      tick(1);  expect_pulls(0, 0, 1, 1, "R6 drop one edge after disable");
      en = 1'b1;
      tick(20); expect_pulls(0, 1, 1, 1, "R6 resumes after enable");
      a_ext = 1'b0;
      tick(30); expect_pulls(0, 0, 1, 1, "R1 idle at end");

      checks++;
      if (overlap != 0) begin
         fails++;
         $display("FAIL R9 overlap cycles=%0d expected 0", overlap);
      end
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule